// File: doc/BRIEF.md
# Mode-Switchable Receive Byte Queue

This block holds received bytes for a 16550-style serial port until the data-register read path takes them. It has two modes, selected at run time through a control register. In legacy mode it is a single holding register. In queued mode it is a first-in first-out buffer of `DEPTH` bytes, 16 by default. Bytes arrive on a push port from the line receiver or from the loopback path. The read path removes them with a pop strobe and takes the head byte from `pop_data_o` in that same cycle.

The control register takes writes through a strobe and a data byte. Whenever a write changes the mode, the queue is emptied and its capacity is set for the new mode. A write in queued mode can also empty the queue on purpose. A push that arrives while the queue is at capacity is dropped. The stored bytes stay as they are, and the block raises a one-cycle overrun pulse.

Top module: `rxq_top`

## Requirements
- R1: After reset the control register reads 0x00, the count is 0, `not_empty_o` and `full_o` are low, and the capacity is 1 (legacy mode).
- R2: In legacy mode (control bit 0 clear) the capacity is 1. One accepted push makes `full_o` high.
- R3: In queued mode (control bit 0 set) the capacity is `DEPTH`. `full_o` rises only when `DEPTH` bytes are stored.
- R4: A control write whose bit 0 differs from the stored bit 0 empties the queue, in either direction.
- R5: A control write with bit 0 clear stores 0x00 in the whole control register, whatever the other bits are.
- R6: A control write with bit 0 set keeps only bit 0 (enable), bit 3 (DMA mode) and bits 7:6 (receive trigger), which is mask 0xC9. All other bits read back 0.
- R7: A control write with both bit 0 and bit 1 set empties the queue even when the mode does not change. A write with bit 0 set and bit 1 clear, made while already in queued mode, keeps the contents.
- R8: A push made while the count equals the capacity is rejected. The stored bytes are unchanged, and `overrun_o` is high for the one cycle after that push. This holds even when a pop happens in the same cycle: the pop is served and the push is still dropped.
- R9: Bytes leave in the order they were pushed, including after the pointers wrap at the current capacity.
- R10: A pop on an empty queue sees `pop_data_o` = 0xFF, leaves the count at 0 and raises no overrun.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged.
- R12: A control write that empties the queue takes precedence over a push or pop in the same cycle. Both are discarded.
- R13: `pop_data_o` shows the head byte, or 0xFF when the queue is empty, in the same cycle without any register stage. The count, the flags and the control register change at the clock edge that ends the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push a received byte |
| push_data_i | input | 8 | Byte to push |
| pop_i | input | 1 | Pop strobe from the data-register read |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| pop_data_o | output | 8 | Head byte, or 0xFF when empty |
| ctrl_o | output | 8 | Stored control register |
| count_o | output | 5 | Number of stored bytes |
| not_empty_o | output | 1 | At least one byte stored |
| full_o | output | 1 | Count equals the current capacity |
| overrun_o | output | 1 | One-cycle pulse after a rejected push |

## Verification
The head byte on `pop_data_o` is combinational, so the monitor compares it against the front of the reference queue inside the pop cycle, before the edge that consumes it. The count, flags and control readback are due one edge after the request, and the bench samples them one nanosecond after that rising edge. The overrun pulse is due in the cycle that follows the rejected push, so the driver records the expectation and the monitor checks it in the next cycle. The reference model applies pushes only after the monitor has taken its pop, and it decides whether a push is accepted from the size before the pop, which is how the hardware decides.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned RRST_BIT = 1;
  localparam int unsigned DMA_BIT  = 3;
  localparam int unsigned TRG_LSB  = 6;
  localparam logic [DW-1:0] KEEP_MASK =
    DW'((1 << EN_BIT) | (1 << DMA_BIT) | (3 << TRG_LSB));
  localparam logic [DW-1:0] EMPTY_READ = '1;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o,
  output logic          fifo_mode_o,
  output logic          flush_o
);
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic          mode_flip, rx_clear;

  assign mode_flip = wdata_i[EN_BIT] ^ ctrl_q[EN_BIT];
  assign rx_clear  = wdata_i[EN_BIT] & wdata_i[RRST_BIT];
  assign flush_o   = we_i & (mode_flip | rx_clear);
  // with enable clear the whole register reads zero
  assign ctrl_d    = wdata_i[EN_BIT] ? (wdata_i & KEEP_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= ctrl_d;
  end

  assign ctrl_o      = ctrl_q;
  assign fifo_mode_o = ctrl_q[EN_BIT];

  a_r5_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !wdata_i[EN_BIT] |=> ctrl_q == '0);
  a_r6_only_kept_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~KEEP_MASK) == '0);
  a_r1_reset_legacy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> ctrl_q == '0);
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fifo_mode_i,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [DW-1:0]              push_data_i,
  input  logic                       pop_i,
  output logic [DW-1:0]              pop_data_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       not_empty_o,
  output logic                       full_o,
  output logic                       overrun_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] count_q, cap;
  logic          full, empty, push_ok, pop_ok, ovr_q;

  assign cap     = fifo_mode_i ? CW'(DEPTH) : CW'(1);
  assign empty   = (count_q == '0);
  assign full    = (count_q >= cap);
  assign push_ok = push_i & ~full & ~flush_i;
  assign pop_ok  = pop_i & ~empty & ~flush_i;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p, input logic [CW-1:0] c);
    return ((CW'(p) + CW'(1)) >= c) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
      ovr_q    <= 1'b0;
    end else begin
      ovr_q <= push_i & full & ~flush_i;
      if (flush_i) begin
        rd_ptr_q <= '0;
        wr_ptr_q <= '0;
        count_q  <= '0;
      end else begin
        if (push_ok) wr_ptr_q <= bump(wr_ptr_q, cap);
        if (pop_ok)  rd_ptr_q <= bump(rd_ptr_q, cap);
        case ({push_ok, pop_ok})
          2'b10:   count_q <= count_q + CW'(1);
          2'b01:   count_q <= count_q - CW'(1);
          default: count_q <= count_q;
        endcase
      end
    end
  end

  assign pop_data_o  = empty ? EMPTY_READ : mem[rd_ptr_q];
  assign count_o     = count_q;
  assign not_empty_o = ~empty;
  assign full_o      = full;
  assign overrun_o   = ovr_q;

  a_r3_fill_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= cap);
  a_r4_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_q == '0);
  a_r8_no_growth_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full && !pop_i && !flush_i |=> count_q == $past(count_q));
  a_r10_empty_pop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty && pop_i && !push_i |=> count_q == '0 && !ovr_q);
  a_r11_balanced_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !empty && !full && !flush_i |=> $stable(count_q));
  a_r2_legacy_ptrs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_mode_i && !flush_i |-> rd_ptr_q == '0 && wr_ptr_q == '0);
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [7:0]                 push_data_i,
  input  logic                       pop_i,
  input  logic                       ctrl_we_i,
  input  logic [7:0]                 ctrl_wdata_i,
  output logic [7:0]                 pop_data_o,
  output logic [7:0]                 ctrl_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       not_empty_o,
  output logic                       full_o,
  output logic                       overrun_o
);
  logic fifo_mode, flush;

  rxq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctrl_we_i),
    .wdata_i     (ctrl_wdata_i),
    .ctrl_o      (ctrl_o),
    .fifo_mode_o (fifo_mode),
    .flush_o     (flush)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_mode_i (fifo_mode),
    .flush_i     (flush),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop_i),
    .pop_data_o  (pop_data_o),
    .count_o     (count_o),
    .not_empty_o (not_empty_o),
    .full_o      (full_o),
    .overrun_o   (overrun_o)
  );

  a_r12_flush_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush && push_i |=> count_o == '0);
endmodule

// File: tb/sim_rxq_top.sv
`timescale 1ns/1ps
module sim_rxq_top;
  localparam int DEPTH = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_i = 1'b0, pop_i = 1'b0, ctrl_we_i = 1'b0;
  logic [7:0] push_data_i = '0, ctrl_wdata_i = '0;
  logic [7:0] pop_data_o, ctrl_o;
  logic [4:0] count_o;
  logic       not_empty_o, full_o, overrun_o;

  always #2.5 clk_i = ~clk_i;

  rxq_top #(.DEPTH(DEPTH)) u0 (.*);

  int   n_run = 0, n_fail = 0;
  logic [7:0] mq[$];
  logic [7:0] mctrl = 8'h00;
  int   mcap = 1;
  bit   armed = 0, cur_flush = 0, ovr_next = 0, ovr_chk = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, model updated after the monitor has sampled
  task automatic cyc(input logic p, input logic [7:0] d, input logic q,
                     input logic w, input logic [7:0] wd);
    int pre;
    bit fl;
    @(negedge clk_i);
    push_i = p; push_data_i = d; pop_i = q; ctrl_we_i = w; ctrl_wdata_i = wd;
    ovr_chk = ovr_next; ovr_next = 0;
    pre = mq.size();
    fl = w && ((wd[0] != mctrl[0]) || (wd[0] && wd[1]));
    cur_flush = fl;
    armed = 1;
    #2;
    if (fl) mq.delete();
    else if (p) begin
      if (pre < mcap) mq.push_back(d);
      else ovr_next = 1;
    end
    if (w) begin
      mctrl = wd[0] ? (wd & 8'hC9) : 8'h00;
      mcap  = mctrl[0] ? DEPTH : 1;
    end
  endtask

  task automatic idle();
    cyc(0, 8'h00, 0, 0, 8'h00);
  endtask

  // monitor: head byte and overrun checked inside each cycle before the edge
  always @(negedge clk_i) begin
    #1;
    if (armed) begin
      chk(overrun_o == ovr_chk, "R8 overrun pulse", 32'(overrun_o), 32'(ovr_chk));
      if (pop_i && !cur_flush) begin
        if (mq.size() == 0)
          chk(pop_data_o == 8'hFF, "R10 empty pop data", 32'(pop_data_o), 32'hFF);
        else begin
          chk(pop_data_o == mq[0], "R9 pop order", 32'(pop_data_o), 32'(mq[0]));
          void'(mq.pop_front());
        end
      end
    end
  end

  task automatic check_state(input string req);
    @(posedge clk_i);
    #1;
    chk(count_o == 5'(mq.size()), {req, " count"}, 32'(count_o), 32'(mq.size()));
    chk(not_empty_o == (mq.size() > 0), {req, " not_empty"}, 32'(not_empty_o), 32'(mq.size() > 0));
    chk(full_o == (mq.size() == mcap), {req, " full"}, 32'(full_o), 32'(mq.size() == mcap));
    chk(ctrl_o == mctrl, {req, " ctrl"}, 32'(ctrl_o), 32'(mctrl));
    // R13: head byte visible without a pop
    if (mq.size() > 0)
      chk(pop_data_o == mq[0], "R13 head visible", 32'(pop_data_o), 32'(mq[0]));
    else
      chk(pop_data_o == 8'hFF, "R13 empty head", 32'(pop_data_o), 32'hFF);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check_state("R1 reset");

    // R2 legacy capacity 1, R8 overrun keeps the byte
    cyc(1, 8'hA5, 0, 0, 8'h00); check_state("R2 legacy one");
    cyc(1, 8'h3C, 0, 0, 8'h00); check_state("R8 legacy reject");
    idle();
    cyc(0, 8'h00, 1, 0, 8'h00); check_state("R2 legacy pop");

    // R10 empty pop
    cyc(0, 8'h00, 1, 0, 8'h00); check_state("R10 empty pop");
    idle();

    // R5 enable clear stores zero
    cyc(0, 8'h00, 0, 1, 8'hFE); check_state("R5 zero store");

    // R6 mask, R3 capacity DEPTH
    cyc(0, 8'h00, 0, 1, 8'hFF); check_state("R6 kept bits");
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(8'h10 + i), 0, 0, 8'h00);
    check_state("R3 full at depth");
    cyc(1, 8'hEE, 0, 0, 8'h00); check_state("R8 queued reject");
    idle();
    for (int i = 0; i < 5; i++) cyc(0, 8'h00, 1, 0, 8'h00);
    for (int i = 0; i < 5; i++) cyc(1, 8'(8'h60 + i), 0, 0, 8'h00);
    check_state("R9 wrapped refill");
    for (int i = 0; i < DEPTH; i++) cyc(0, 8'h00, 1, 0, 8'h00);
    check_state("R9 drained");

    // R11 push and pop together
    for (int i = 0; i < 3; i++) cyc(1, 8'(8'h70 + i), 0, 0, 8'h00);
    cyc(1, 8'h7F, 1, 0, 8'h00); check_state("R11 balanced");

    // R7 no reset keeps, reset bit empties
    cyc(0, 8'h00, 0, 1, 8'h09); check_state("R7 keep contents");
    cyc(0, 8'h00, 0, 1, 8'h03); check_state("R7 rx reset");

    // R4 queued to legacy flushes and capacity drops to 1
    cyc(1, 8'h81, 0, 0, 8'h00);
    cyc(1, 8'h82, 0, 0, 8'h00);
    cyc(0, 8'h00, 0, 1, 8'h00); check_state("R4 leave queued");
    cyc(1, 8'h91, 0, 0, 8'h00);
    cyc(1, 8'h92, 0, 0, 8'h00); check_state("R4 legacy cap");
    idle();

    // R8 push and pop on a full legacy queue
    cyc(1, 8'hB0, 1, 0, 8'h00); check_state("R8 full push pop");
    idle();

    // R4 legacy to queued flushes
    cyc(1, 8'hC1, 0, 0, 8'h00);
    cyc(0, 8'h00, 0, 1, 8'h01); check_state("R4 enter queued");

    // R12 flush beats push and pop in the same cycle
    cyc(1, 8'hD1, 0, 0, 8'h00);
    cyc(1, 8'hD2, 1, 1, 8'h03); check_state("R12 flush wins");
    idle(); idle();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule